// File: doc/BRIEF.md
# Folded Two-Way Tape Head

This block is the head of a tape that runs without end in both directions, built on a one-sided memory of cells. Each cell has two tracks. The upper track holds virtual positions 0, 1, 2 and onward. The lower track holds positions -1, -2 and onward, with cell i holding position -i. Cell 0 of the lower track keeps a reserved marker code. The head never rests there; instead, reaching it sends the head back to the upper track.

A tape-machine controller issues one command per valid cycle. Each command carries a move (stay, left or right) and an optional symbol to write. The symbol is written under the head first, and then the head moves. The controller works only with virtual left and right. The block tracks which track is active and reverses the physical direction on the lower track. The cycle after each command, the block returns the symbol now under the head and the signed virtual position. A move that would leave the physical memory is dropped and reported on a flag. The write in the same command still takes place.

Top module: `fold_tape_head`

## Requirements
- R1: While rst_ni is low and after its release, the head is at virtual position 0 on the upper track (bot_trk_o=0, cell_o=0). rd_valid_o and ovf_o are 0, and every reachable cell of both tracks reads the blank code 0.
- R2: An accepted command (cmd_valid_i=1) with wr_en_i=1 stores wr_sym_i in the cell under the head before the move. From the next cycle, rd_sym_o shows the symbol stored at the new head position.
- R3: On the upper track at cell 0, a left command moves the head to cell 1 and switches it to the lower track (virtual position -1).
- R4: On the lower track, moves are inverted. A virtual left raises cell_o by one, and a virtual right lowers it by one.
- R5: On the lower track at cell 1, a right command moves the head to cell 0 and switches it to the upper track (virtual position 0). The head is never on the lower track at cell 0.
- R6: On the upper track away from the cell-0 wrap, a left lowers cell_o by one and a right raises it by one.
- R7: If a move would go past physical cell CELLS-1 on either track, the head stays where it is. ovf_o is 1 for the one cycle after that command, and any write in that command still takes place.
- R8: A cycle with cmd_valid_i=0 writes nothing and moves nothing, whatever wr_en_i, wr_sym_i and cmd_move_i hold. rd_valid_o is 0 in the cycle after it.
- R9: cmd_move_i encodes 2'b00 as stay, 2'b01 as left and 2'b10 as right. 2'b11 is also treated as stay.
- R10: rd_valid_o is 1 in exactly the cycle after each accepted command, and pos_o equals the virtual position (cell_o if bot_trk_o=0, else -cell_o).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command accepted this cycle |
| cmd_move_i | input | 2 | Virtual move: 00 stay, 01 left, 10 right, 11 stay |
| wr_en_i | input | 1 | Write wr_sym_i under the head before the move |
| wr_sym_i | input | SYM_W | Symbol to write |
| rd_valid_o | output | 1 | Result of the previous command is shown |
| rd_sym_o | output | SYM_W | Symbol under the head |
| pos_o | output | $clog2(CELLS)+1 | Signed virtual head position |
| bot_trk_o | output | 1 | Head is on the lower (negative) track |
| cell_o | output | $clog2(CELLS) | Physical cell index |
| ovf_o | output | 1 | Previous command's move was dropped at the memory edge |

## Verification
Every result of a command is due exactly one clock edge after the edge that accepts it: the head registers, the written cell, rd_valid_o and ovf_o all update on that edge, and rd_sym_o follows the new registers through a combinational read. The bench changes inputs on the falling edge and samples on the next falling edge, so it samples half a cycle after the single edge that counts. Idle cycles are checked the same way, one falling edge after they are driven, to confirm that nothing changed.

// File: rtl/fold_tape_pkg.sv
package fold_tape_pkg;
  typedef enum logic [1:0] {
    MV_STAY  = 2'b00,
    MV_LEFT  = 2'b01,
    MV_RIGHT = 2'b10,
    MV_HOLD  = 2'b11
  } move_e;
endpackage

// File: rtl/fold_tape_nav.sv
module fold_tape_nav
  import fold_tape_pkg::*;
#(
  parameter int CELLS = 16,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic             bot_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       move_i,
  output logic             bot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             ovf_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELLS - 1);
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

  move_e mv;
  logic  phys_up, phys_dn;

  always_comb begin
    mv = move_e'(move_i);
    // lower track runs mirrored
    phys_up = (mv == MV_RIGHT && !bot_i) || (mv == MV_LEFT  && bot_i);
    phys_dn = (mv == MV_LEFT  && !bot_i) || (mv == MV_RIGHT && bot_i);
    bot_o = bot_i;
    idx_o = idx_i;
    ovf_o = 1'b0;
    if (phys_up) begin
      if (idx_i == LAST) ovf_o = 1'b1;
      else               idx_o = idx_i + ONE;
    end else if (phys_dn) begin
      if (!bot_i && idx_i == '0) begin
        // fold: step onto lower track
        if (LAST == '0) ovf_o = 1'b1;
        else begin
          idx_o = ONE;
          bot_o = 1'b1;
        end
      end else begin
        idx_o = idx_i - ONE;
        if (bot_i && idx_i == ONE) bot_o = 1'b0; // marker reached
      end
    end
  end
endmodule

// File: rtl/fold_tape_mem.sv
module fold_tape_mem #(
  parameter int              SYM_W = 4,
  parameter int              CELLS = 16,
  parameter logic [SYM_W-1:0] BLANK = '0,
  parameter logic [SYM_W-1:0] MARK  = '1,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             trk_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SYM_W-1:0] wr_sym_i,
  output logic [SYM_W-1:0] rd_sym_o
);
  logic [SYM_W-1:0] trk_rd [2];

  for (genvar g = 0; g < 2; g++) begin : g_trk
    localparam bit IS_BOT = (g == 1);
    logic [SYM_W-1:0] cell_q [CELLS];
    logic             wr_hit;

    assign wr_hit = we_i && (trk_i == IS_BOT) && !(IS_BOT && idx_i == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int c = 0; c < CELLS; c++)
          cell_q[c] <= (IS_BOT && c == 0) ? MARK : BLANK;
      end else if (wr_hit) begin
        cell_q[idx_i] <= wr_sym_i;
      end
    end

    assign trk_rd[g] = cell_q[idx_i];
  end

  assign rd_sym_o = trk_rd[trk_i];
endmodule

// File: rtl/fold_tape_head.sv
module fold_tape_head
  import fold_tape_pkg::*;
#(
  parameter int              SYM_W = 4,
  parameter int              CELLS = 16,
  parameter logic [SYM_W-1:0] BLANK = '0,
  parameter logic [SYM_W-1:0] MARK  = '1,
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_move_i,
  input  logic               wr_en_i,
  input  logic [SYM_W-1:0]   wr_sym_i,
  output logic               rd_valid_o,
  output logic [SYM_W-1:0]   rd_sym_o,
  output logic signed [IDX_W:0] pos_o,
  output logic               bot_trk_o,
  output logic [IDX_W-1:0]   cell_o,
  output logic               ovf_o
);
  logic             bot_q, bot_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ovf_d;
  logic             vld_q, ovf_q;

  fold_tape_nav #(.CELLS(CELLS)) u_nav (
    .bot_i  (bot_q),
    .idx_i  (idx_q),
    .move_i (cmd_move_i),
    .bot_o  (bot_d),
    .idx_o  (idx_d),
    .ovf_o  (ovf_d)
  );

  // write lands at the pre-move cell; read follows the registered head
  fold_tape_mem #(
    .SYM_W(SYM_W), .CELLS(CELLS), .BLANK(BLANK), .MARK(MARK)
  ) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cmd_valid_i && wr_en_i),
    .trk_i    (bot_q),
    .idx_i    (idx_q),
    .wr_sym_i (wr_sym_i),
    .rd_sym_o (rd_sym_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bot_q <= 1'b0;
      idx_q <= '0;
      vld_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      vld_q <= cmd_valid_i;
      ovf_q <= cmd_valid_i && ovf_d;
      if (cmd_valid_i) begin
        bot_q <= bot_d;
        idx_q <= idx_d;
      end
    end
  end

  logic signed [IDX_W:0] mag;
  assign mag        = $signed({1'b0, idx_q});
  assign pos_o      = bot_q ? -mag : mag;
  assign bot_trk_o  = bot_q;
  assign cell_o     = idx_q;
  assign rd_valid_o = vld_q;
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/fold_tape_head_chk.sv
module fold_tape_head_chk #(
  parameter int CELLS = 16,
  localparam int IDX_W = $clog2(CELLS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_move_i,
  input logic             rd_valid_o,
  input logic             ovf_o,
  input logic             bot_trk_o,
  input logic [IDX_W-1:0] cell_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELLS - 1);

  // R3
  top_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !bot_trk_o && cell_o == '0 && cmd_move_i == 2'b01 && CELLS > 1
    |=> bot_trk_o && cell_o == IDX_W'(1));

  // R5
  bot_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && bot_trk_o && cell_o == IDX_W'(1) && cmd_move_i == 2'b10
    |=> !bot_trk_o && cell_o == '0);

  // R5
  no_bot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bot_trk_o |-> cell_o != '0);

  // R4
  bot_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && bot_trk_o && cmd_move_i == 2'b01 && cell_o != LAST
    |=> bot_trk_o && cell_o == $past(cell_o) + IDX_W'(1));

  // R7
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $stable(cell_o) && $stable(bot_trk_o));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(cell_o) && $stable(bot_trk_o) && !rd_valid_o);

  // R10
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rd_valid_o);
endmodule

bind fold_tape_head fold_tape_head_chk #(.CELLS(CELLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_move_i  (cmd_move_i),
  .rd_valid_o  (rd_valid_o),
  .ovf_o       (ovf_o),
  .bot_trk_o   (bot_trk_o),
  .cell_o      (cell_o)
);

// File: tb/fold_tape_head_tb.sv
`timescale 1ns/1ps
module fold_tape_head_tb;
  localparam int SYM_W = 4;
  localparam int CELLS = 16;
  localparam int IDX_W = $clog2(CELLS);
  localparam int SPAN  = 2 * CELLS - 1;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               cmd_valid_i = 1'b0;
  logic [1:0]         cmd_move_i = 2'b00;
  logic               wr_en_i = 1'b0;
  logic [SYM_W-1:0]   wr_sym_i = '0;
  logic               rd_valid_o;
  logic [SYM_W-1:0]   rd_sym_o;
  logic signed [IDX_W:0] pos_o;
  logic               bot_trk_o;
  logic [IDX_W-1:0]   cell_o;
  logic               ovf_o;

  fold_tape_head #(.SYM_W(SYM_W), .CELLS(CELLS)) u_dut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int vpos;
  int vt [SPAN];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cell_of(input int p);
    return (p < 0) ? -p : p;
  endfunction

  task automatic check_head(input string req, input bit exp_vld, input bit exp_ovf);
    chk(int'(pos_o) == vpos, {req, " pos"}, int'(pos_o), vpos);
    chk(int'(cell_o) == cell_of(vpos), {req, " cell"}, int'(cell_o), cell_of(vpos));
    chk(bot_trk_o == (vpos < 0), {req, " track"}, int'(bot_trk_o), int'(vpos < 0));
    chk(int'(rd_sym_o) == vt[vpos + CELLS - 1], {req, " R2 sym"}, int'(rd_sym_o),
        vt[vpos + CELLS - 1]);
    chk(rd_valid_o == exp_vld, {req, " R10 valid"}, int'(rd_valid_o), int'(exp_vld));
    chk(ovf_o == exp_ovf, {req, " R7 ovf"}, int'(ovf_o), int'(exp_ovf));
  endtask

  // one accepted command; checked one falling edge later
  task automatic do_cmd(input logic [1:0] mv, input bit we, input int sym);
    int    nv;
    bit    ov;
    string req;
    @(negedge clk_i);
    cmd_valid_i = 1'b1;
    cmd_move_i  = mv;
    wr_en_i     = we;
    wr_sym_i    = SYM_W'(sym);
    if (we) vt[vpos + CELLS - 1] = sym;
    nv = vpos + ((mv == 2'b01) ? -1 : (mv == 2'b10) ? 1 : 0);
    ov = (nv > CELLS - 1) || (nv < -(CELLS - 1));
    if (ov) req = "R7";
    else if (mv == 2'b11) req = "R9";
    else if (vpos == 0 && mv == 2'b01) req = "R3";
    else if (vpos == -1 && mv == 2'b10) req = "R5";
    else if (vpos < 0) req = "R4";
    else req = "R6";
    if (!ov) vpos = nv;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    wr_en_i     = 1'b0;
    check_head(req, 1'b1, ov);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    vpos = 0;
    for (int i = 0; i < SPAN; i++) vt[i] = 0;

    // R1 during and after reset
    #7;
    check_head("R1", 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_head("R1", 1'b0, 1'b0);

    // R3 fold onto lower track, R2 write before move
    do_cmd(2'b01, 1'b1, 3);
    do_cmd(2'b01, 1'b1, 7);
    do_cmd(2'b01, 1'b0, 0);
    // R4 inverted moves back toward marker
    do_cmd(2'b10, 1'b0, 0);
    do_cmd(2'b10, 1'b1, 9);
    // R5 return through the marker
    do_cmd(2'b10, 1'b0, 0);
    // R9 code 11 holds the head, stay with write shows new symbol
    do_cmd(2'b11, 1'b1, 5);
    do_cmd(2'b00, 1'b1, 6);

    // R8 idle cycle with stray write and move
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    wr_en_i     = 1'b1;
    wr_sym_i    = 4'd12;
    cmd_move_i  = 2'b10;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check_head("R8", 1'b0, 1'b0);

    // R6 walk to the upper edge, R7 overflow with write
    for (int i = 0; i < CELLS - 1; i++) do_cmd(2'b10, 1'b1, i % 14 + 1);
    do_cmd(2'b10, 1'b1, 13);
    do_cmd(2'b01, 1'b0, 0);
    // R7 lower edge
    for (int i = 0; i < 2 * CELLS; i++) do_cmd(2'b01, 1'b0, 0);
    do_cmd(2'b01, 1'b1, 11);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      do_cmd((r < 4) ? 2'b01 : (r < 8) ? 2'b10 : (r == 8) ? 2'b00 : 2'b11,
             bit'($urandom_range(0, 1)), int'($urandom_range(0, 14)));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule